// File: doc/BRIEF.md
# Supply Reset Generator with Window Watchdog

This block drives an active-low system reset. It holds the reset until the supply has been good for a set number of time-base ticks. After release, it watches a microcontroller through a window watchdog. The microcontroller services the watchdog by toggling a trigger bit in its serial control word. The block counts all time in ticks of an internal time base. A tick is a one-clock pulse on `tick`.

After release, the watchdog first gives a long open window. Once the first service arrives, every period has two parts: a closed window, where any service counts as a fault, and then an open window, where the service must arrive. A fault pulls the reset low for a few ticks and raises a sticky diagnostic flag. Both a fault and a supply drop pulse `clr_ctrl` so the surrounding logic can clear its control-word bits. The watchdog is suspended during undercurrent sleep. When sleep ends, it restarts with the long window so the two sides can synchronise again. A flash-programming input disables the watchdog.

States: HOLD (supply reset, counting release ticks), LONG (long open window), CLOSED, OPEN, WDRST (watchdog reset pulse), SUSPEND (undercurrent sleep), DISABLED (flash mode). Transitions:
- HOLD→LONG when the release count ends.
- LONG→CLOSED on a service.
- LONG→WDRST when the long window expires.
- CLOSED→WDRST on a service.
- CLOSED→OPEN when the closed window ends.
- OPEN→CLOSED on a service.
- OPEN→WDRST when the open window expires.
- WDRST→LONG when the pulse ends.
- LONG, CLOSED or OPEN→SUSPEND on a sleep request, and SUSPEND→LONG when it ends.
- LONG, CLOSED, OPEN or SUSPEND→DISABLED on flash mode, and DISABLED→LONG when it ends.
- Any state→HOLD when the supply is low.

Top module: `rst_wdog_gen`

## Requirements
- R1: While `supply_ok` is high, `rst_out_n` is released on the 16th tick counted in HOLD. Ticks before that keep it low. A supply drop during HOLD restarts the count.
- R2: When `supply_ok` is low, `rst_out_n` is low in the same cycle. If the reset was released, `clr_ctrl` is also high in that cycle.
- R3: The long open window lasts 32 ticks. A service on any of those ticks, including the 32nd, starts a closed window. If no service arrives by the 32nd tick, a watchdog reset starts.
- R4: A service is recognised on the tick whose sample of `trig_bit`, together with the three samples before it (one sample per tick), reads high, high, low, low from oldest to newest.
- R5: A closed window lasts 12 ticks, and a service inside it starts a watchdog reset. The open window that follows lasts 20 ticks. A service inside it (including the 20th tick) starts a new closed window. No service by its 20th tick starts a watchdog reset.
- R6: A watchdog reset raises `clr_ctrl` for one clock in the cycle of the faulting tick. `rst_out_n` is low from the next clock for 4 ticks, and a long open window then follows.
- R7: `wd_rst_flag` rises after a watchdog reset. It stays high until a cycle with `diag_read` high clears it. A new watchdog reset in that same cycle wins.
- R8: With `uc_sleep_en` and `low_current` both high, the watchdog is suspended and no reset occurs. `low_current` alone has no effect. When the request ends, a 32-tick long open window follows.
- R9: With `flash_mode` high, the watchdog is disabled and services are ignored. When it falls, a long open window follows.
- R10: While `rst_out_n` is low, trigger samples are discarded. A pattern that is only completed after release is not recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| tick | input | 1 | One-clock pulse of the internal time base |
| supply_ok | input | 1 | Regulated supply is above the reset threshold |
| trig_bit | input | 1 | Watchdog service bit of the current control word |
| uc_sleep_en | input | 1 | Undercurrent suspension is enabled |
| low_current | input | 1 | Load current is below the undercurrent limit |
| flash_mode | input | 1 | Flash programming mode; disables the watchdog |
| diag_read | input | 1 | Diagnostic word read; clears the sticky flag |
| rst_out_n | output | 1 | Active-low system reset |
| wd_rst_flag | output | 1 | Sticky flag: a watchdog reset has occurred |
| clr_ctrl | output | 1 | One-clock request to clear all control-word bits |

## Verification
The bound checker checks these rules on every cycle:
- the reset follows a supply drop at once, and the clear pulse comes with it;
- the reset is only ever released on a tick;
- the clear pulse lasts a single clock;
- the flag only rises after a clear pulse and holds until it is read;
- the reset never falls while flash mode persists.

The window lengths, the exact tick of a service relative to the closed/open boundary, the four-tick reset pulse, resynchronisation after sleep or flash mode, and the discarding of samples during reset are shown only by the bench's scenarios. Those scenarios count ticks against expected positions.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LONG,
        ST_CLOSED,
        ST_OPEN,
        ST_WDRST,
        ST_SUSPEND,
        ST_DISABLED
    } rwd_state_e;

endpackage

// File: rtl/rwd_trig_detect.sv
// Samples the service bit once per tick and flags the high..high,low..low pattern.
module rwd_trig_detect #(
    parameter int HI_N = 2,
    parameter int LO_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic trig_bit,
    output logic trig_evt
);
    localparam int LEN = HI_N + LO_N;
    localparam logic [LEN-1:0] PATTERN = {{HI_N{1'b1}}, {LO_N{1'b0}}};

    logic [LEN-1:0] hist_q;
    logic [LEN-1:0] hist_next;

    // Newest sample enters at bit 0, oldest sits at the top.
    assign hist_next = {hist_q[LEN-2:0], trig_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (tick) begin
            hist_q <= hist_next;
        end
    end

    assign trig_evt = tick && !clear && (hist_next == PATTERN);

endmodule

// File: rtl/rwd_sticky_flag.sv
// Diagnostic flag: set dominates clear.
module rwd_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rwd_fsm.sv
// Reset and watchdog window sequencer; all durations in time-base ticks.
module rwd_fsm
    import rwd_pkg::*;
#(
    parameter int POR_TICKS    = 16,
    parameter int LONG_TICKS   = 32,
    parameter int CLOSED_TICKS = 12,
    parameter int OPEN_TICKS   = 20,
    parameter int WDR_TICKS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic trig_evt,
    input  logic susp_req,
    input  logic flash_mode,
    output logic rst_out_n,
    output logic wdr_enter,
    output logic por_enter
);
    localparam int MAX_AB = (POR_TICKS > LONG_TICKS) ? POR_TICKS : LONG_TICKS;
    localparam int MAX_CD = (CLOSED_TICKS > OPEN_TICKS) ? CLOSED_TICKS : OPEN_TICKS;
    localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAX_T = (MAX_ABCD > WDR_TICKS) ? MAX_ABCD : WDR_TICKS;
    localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

    localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_TICKS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST   = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] CLOSED_LAST = CNT_W'(CLOSED_TICKS - 1);
    localparam logic [CNT_W-1:0] OPEN_LAST   = CNT_W'(OPEN_TICKS - 1);
    localparam logic [CNT_W-1:0] WDR_LAST    = CNT_W'(WDR_TICKS - 1);

    rwd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             win_done;

    always_comb begin
        unique case (state_q)
            ST_HOLD:   limit = POR_LAST;
            ST_LONG:   limit = LONG_LAST;
            ST_CLOSED: limit = CLOSED_LAST;
            ST_OPEN:   limit = OPEN_LAST;
            ST_WDRST:  limit = WDR_LAST;
            default:   limit = '0;
        endcase
    end

    assign win_done = tick && (cnt_q == limit);

    // State register and tick counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_d != state_q) || !supply_ok) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    if (win_done) state_d = ST_LONG;
                end
                ST_LONG: begin
                    if (flash_mode)    state_d = ST_DISABLED;
                    else if (susp_req) state_d = ST_SUSPEND;
                    else if (trig_evt) state_d = ST_CLOSED;
                    else if (win_done) state_d = ST_WDRST;
                end
                ST_CLOSED: begin
                    if (flash_mode)    state_d = ST_DISABLED;
                    else if (susp_req) state_d = ST_SUSPEND;
                    else if (trig_evt) state_d = ST_WDRST;
                    else if (win_done) state_d = ST_OPEN;
                end
                ST_OPEN: begin
                    if (flash_mode)    state_d = ST_DISABLED;
                    else if (susp_req) state_d = ST_SUSPEND;
                    else if (trig_evt) state_d = ST_CLOSED;
                    else if (win_done) state_d = ST_WDRST;
                end
                ST_WDRST: begin
                    if (win_done) state_d = ST_LONG;
                end
                ST_SUSPEND: begin
                    if (flash_mode)     state_d = ST_DISABLED;
                    else if (!susp_req) state_d = ST_LONG;
                end
                ST_DISABLED: begin
                    if (!flash_mode) state_d = ST_LONG;
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        rst_out_n = supply_ok && (state_q != ST_HOLD) && (state_q != ST_WDRST);
        wdr_enter = (state_d == ST_WDRST) && (state_q != ST_WDRST);
        por_enter = (state_d == ST_HOLD) && (state_q != ST_HOLD);
    end

endmodule

// File: rtl/rst_wdog_gen.sv
module rst_wdog_gen #(
    parameter int POR_TICKS    = 16,
    parameter int LONG_TICKS   = 32,
    parameter int CLOSED_TICKS = 12,
    parameter int OPEN_TICKS   = 20,
    parameter int WDR_TICKS    = 4,
    parameter int TRIG_HI_N    = 2,
    parameter int TRIG_LO_N    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic trig_bit,
    input  logic uc_sleep_en,
    input  logic low_current,
    input  logic flash_mode,
    input  logic diag_read,
    output logic rst_out_n,
    output logic wd_rst_flag,
    output logic clr_ctrl
);
    logic trig_evt;
    logic wdr_enter;
    logic por_enter;
    logic susp_req;

    assign susp_req = uc_sleep_en && low_current;

    rwd_trig_detect #(
        .HI_N(TRIG_HI_N),
        .LO_N(TRIG_LO_N)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (!rst_out_n),
        .trig_bit(trig_bit),
        .trig_evt(trig_evt)
    );

    rwd_fsm #(
        .POR_TICKS   (POR_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CLOSED_TICKS(CLOSED_TICKS),
        .OPEN_TICKS  (OPEN_TICKS),
        .WDR_TICKS   (WDR_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .trig_evt  (trig_evt),
        .susp_req  (susp_req),
        .flash_mode(flash_mode),
        .rst_out_n (rst_out_n),
        .wdr_enter (wdr_enter),
        .por_enter (por_enter)
    );

    rwd_sticky_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (wdr_enter),
        .clear(diag_read),
        .flag (wd_rst_flag)
    );

    assign clr_ctrl = wdr_enter || por_enter;

endmodule

// File: rtl/rst_wdog_gen_chk.sv
module rst_wdog_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic supply_ok,
    input logic flash_mode,
    input logic diag_read,
    input logic rst_out_n,
    input logic wd_rst_flag,
    input logic clr_ctrl
);
    // R2
    supply_low_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !rst_out_n);

    // R2
    supply_fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(supply_ok) && $past(rst_out_n)) |-> clr_ctrl);

    // R1
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tick));

    // R6
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ctrl && supply_ok) |=> (!clr_ctrl || !supply_ok));

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_flag) |-> $past(clr_ctrl));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_rst_flag && !diag_read) |=> wd_rst_flag);

    // R9
    flash_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_mode && $past(flash_mode) && rst_out_n) |=> (rst_out_n || !supply_ok));

endmodule

bind rst_wdog_gen rst_wdog_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .supply_ok  (supply_ok),
    .flash_mode (flash_mode),
    .diag_read  (diag_read),
    .rst_out_n  (rst_out_n),
    .wd_rst_flag(wd_rst_flag),
    .clr_ctrl   (clr_ctrl)
);

// File: tb/rst_wdog_gen_bench.sv
`timescale 1ns/1ps
module rst_wdog_gen_bench;
    localparam int POR_T    = 16;
    localparam int LONG_T   = 32;
    localparam int CLOSED_T = 12;
    localparam int OPEN_T   = 20;
    localparam int WDR_T    = 4;

    logic clk = 1'b0;
    logic rst_n, tick, supply_ok, trig_bit, uc_sleep_en, low_current, flash_mode, diag_read;
    logic rst_out_n, wd_rst_flag, clr_ctrl;

    int  n_chk = 0;
    int  n_err = 0;
    bit  last_clr;
    bit  done = 0;

    always #2 clk = ~clk;

    rst_wdog_gen u_rst_wdog_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .trig_bit(trig_bit), .uc_sleep_en(uc_sleep_en), .low_current(low_current),
        .flash_mode(flash_mode), .diag_read(diag_read),
        .rst_out_n(rst_out_n), .wd_rst_flag(wd_rst_flag), .clr_ctrl(clr_ctrl)
    );

    // Service inside a period counted from the start of a closed window (R5).
    function automatic bit svc_in_open(int pos);
        return (pos > CLOSED_T) && (pos <= CLOSED_T + OPEN_T);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        #1 last_clr = clr_ctrl;
        @(negedge clk);
        tick = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    // Four samples: high, high, low, low; the event lands on the last tick (R4).
    task automatic pulse_trig();
        trig_bit = 1'b1;
        do_tick();
        do_tick();
        trig_bit = 1'b0;
        do_tick();
        do_tick();
    endtask

    task automatic read_diag();
        @(negedge clk);
        diag_read = 1'b1;
        @(negedge clk);
        diag_read = 1'b0;
    endtask

    // Leave a watchdog reset and service once in the long window: ends in a closed window.
    task automatic recover();
        idle(WDR_T);
        pulse_trig();
        read_diag();
    endtask

    task automatic service_case(int n);
        int pos;
        idle(n);
        pulse_trig();
        pos = n + 4;
        if (svc_in_open(pos)) begin
            check(rst_out_n == 1'b1, "R5 service in open keeps reset high", rst_out_n, 1);
            check(last_clr == 1'b0, "R5 no clear on valid service", last_clr, 0);
        end else begin
            check(rst_out_n == 1'b0, "R5 service in closed window resets", rst_out_n, 0);
            check(last_clr == 1'b1, "R6 clear pulse on fault", last_clr, 1);
            check(wd_rst_flag == 1'b1, "R7 flag set", wd_rst_flag, 1);
            recover();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst_n = 0; tick = 0; supply_ok = 1; trig_bit = 0;
        uc_sleep_en = 0; low_current = 0; flash_mode = 0; diag_read = 0;
        repeat (3) @(negedge clk);
        check(rst_out_n == 1'b0, "R1 reset state", rst_out_n, 0);
        check(wd_rst_flag == 1'b0, "R7 reset flag", wd_rst_flag, 0);
        check(clr_ctrl == 1'b0, "R6 reset clear", clr_ctrl, 0);
        rst_n = 1;

        // R1 release count
        idle(POR_T - 1);
        check(rst_out_n == 1'b0, "R1 held before last tick", rst_out_n, 0);
        idle(1);
        check(rst_out_n == 1'b1, "R1 released on 16th tick", rst_out_n, 1);

        // R3 long window timeout, R6 pulse, R7 flag
        idle(LONG_T - 1);
        check(rst_out_n == 1'b1, "R3 high through tick 31", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R3 timeout at tick 32", rst_out_n, 0);
        check(last_clr == 1'b1, "R6 clear on timeout tick", last_clr, 1);
        check(wd_rst_flag == 1'b1, "R7 flag after reset", wd_rst_flag, 1);
        idle(WDR_T - 1);
        check(rst_out_n == 1'b0, "R6 low for 3 ticks", rst_out_n, 0);
        idle(1);
        check(rst_out_n == 1'b1, "R6 released after 4 ticks", rst_out_n, 1);
        check(wd_rst_flag == 1'b1, "R7 flag sticky", wd_rst_flag, 1);
        read_diag();
        check(wd_rst_flag == 1'b0, "R7 cleared by read", wd_rst_flag, 0);

        // R3 service on last long tick is valid; R4 pattern
        idle(LONG_T - 4);
        pulse_trig();
        check(rst_out_n == 1'b1, "R3 service on tick 32 valid", rst_out_n, 1);
        check(last_clr == 1'b0, "R4 valid service no clear", last_clr, 0);

        // R5 directed boundaries then random
        service_case(CLOSED_T - 4);
        service_case(CLOSED_T - 3);
        service_case(CLOSED_T + OPEN_T - 4);
        service_case(0);
        for (int k = 0; k < 40; k++) service_case($urandom_range(0, 28));

        // R5 open window timeout
        idle(CLOSED_T + OPEN_T - 1);
        check(rst_out_n == 1'b1, "R5 high before open end", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R5 open window timeout", rst_out_n, 0);
        recover();

        // R10 samples during reset discarded
        service_case(0);
        pulse_trig();
        check(rst_out_n == 1'b0, "R10 setup fault", rst_out_n, 0);
        idle(2);
        trig_bit = 1'b1;
        idle(2);
        trig_bit = 1'b0;
        idle(2);
        check(rst_out_n == 1'b1, "R10 no event from split pattern", rst_out_n, 1);
        idle(LONG_T - 3);
        check(rst_out_n == 1'b1, "R10 long window still running", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R10 timeout proves pattern ignored", rst_out_n, 0);
        recover();

        // R8 low_current alone has no effect
        low_current = 1'b1;
        idle(CLOSED_T + OPEN_T - 1);
        check(rst_out_n == 1'b1, "R8 low current alone", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R8 low current alone still times out", rst_out_n, 0);
        recover();

        // R8 suspension and resync
        uc_sleep_en = 1'b1;
        idle(60);
        pulse_trig();
        idle(10);
        check(rst_out_n == 1'b1, "R8 suspended no reset", rst_out_n, 1);
        check(wd_rst_flag == 1'b0, "R8 suspended no flag", wd_rst_flag, 0);
        low_current = 1'b0;
        idle(1);
        pulse_trig();
        check(rst_out_n == 1'b1, "R8 early service valid after sleep", rst_out_n, 1);
        check(last_clr == 1'b0, "R8 no clear after sleep service", last_clr, 0);
        low_current = 1'b1;
        idle(5);
        low_current = 1'b0;
        idle(LONG_T - 1);
        check(rst_out_n == 1'b1, "R8 32-tick open after sleep", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R8 timeout after resync window", rst_out_n, 0);
        uc_sleep_en = 1'b0;
        recover();

        // R9 flash mode
        flash_mode = 1'b1;
        idle(50);
        pulse_trig();
        idle(10);
        check(rst_out_n == 1'b1, "R9 disabled no reset", rst_out_n, 1);
        flash_mode = 1'b0;
        idle(LONG_T - 1);
        check(rst_out_n == 1'b1, "R9 long window after exit", rst_out_n, 1);
        idle(1);
        check(rst_out_n == 1'b0, "R9 timeout after exit", rst_out_n, 0);
        recover();

        // R2 supply drop, R1 restart of count
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        check(rst_out_n == 1'b0, "R2 immediate reset", rst_out_n, 0);
        check(clr_ctrl == 1'b1, "R2 clear on supply drop", clr_ctrl, 1);
        @(negedge clk);
        supply_ok = 1'b1;
        idle(10);
        check(rst_out_n == 1'b0, "R1 counting", rst_out_n, 0);
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        idle(POR_T - 1);
        check(rst_out_n == 1'b0, "R1 count restarted", rst_out_n, 0);
        idle(1);
        check(rst_out_n == 1'b1, "R1 released after restart", rst_out_n, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule